// File: doc/BRIEF.md
# Iterative Brain-State-in-a-Box Recall Engine

This block runs the recall phase of an autoassociative brain-state-in-a-box network in fixed point. Software or a neighbouring block first writes two non-negative weight matrices, one for the positive part and one for the magnitude of the negative part of the connection matrix. It then writes an initial signed state vector and pulses a start input. Each iteration forms a new vector from the old one as `clip(P·x − M·x + x)`, with both gains fixed at one. Recall stops when every element has been driven onto the rail at plus or minus the bound.

The engine handles one row per clock. New rows go into a shadow buffer, so every row of an iteration sees the same old vector, and the shadow buffer is copied into the live state in one extra cycle. When recall ends, the engine reports the final vector through a read port, together with the number of iterations it took. When several engines recall the same input, the iteration count is the figure used to rank them. A programmable limit stops a recall that never saturates and flags it as a timeout.

Top module: `bsb_recall`

## Requirements
- R1: A write with `wrEn` high and `wrNeg` low stores the unsigned 8-bit `wrData` as P[wrRow][wrCol]. With `wrNeg` high it stores M[wrRow][wrCol]. A weight value of 2^WSHIFT (64 by default) stands for 1.0. Every weight resets to 0.
- R2: A write with `xWrEn` high stores the signed 16-bit `xWrData` as state element `xWrIdx`. `rdData` returns state element `rdIdx` combinationally. After a recall ends it shows the final vector.
- R3: One iteration sets x'[i] = clip(floor(Σj (P[i][j] − M[i][j])·x[j] / 2^WSHIFT) + x[i]). Every row uses the vector from before the iteration, and the sum is exact in a 32-bit signed accumulator.
- R4: The clip passes a value strictly between −B and +B unchanged and replaces any value ≥ B with +B and any value ≤ −B with −B. B is the BOUND parameter, 1024 by default.
- R5: Recall ends with `done` high right after the first iteration in which every element of the new vector equals +B or −B.
- R6: If an iteration ends without convergence and the iteration count has reached `maxIter`, recall ends with `timeout` high. Convergence in that same iteration wins, giving `done` and not `timeout`. A `maxIter` of 0 ends recall after one iteration.
- R7: `iterCount` gives the number of iterations completed. One iteration takes N+1 clocks, so the result flag rises k·(N+1) clock edges after the edge that accepted start, where k is the final count.
- R8: `busy` is high from the edge that accepts `start` until recall ends. `done` and `timeout` clear when a start is accepted, hold until the next accepted start, and are never both high. Neither is high while `busy` is high.
- R9: While `busy` is high, `start`, weight writes and state writes have no effect.
- R10: After reset, `busy`, `done` and `timeout` are low, `iterCount` is 0 and every state element reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Weight write strobe |
| wrNeg | input | 1 | 0 selects matrix P, 1 selects matrix M |
| wrRow | input | IDX_W | Weight row address |
| wrCol | input | IDX_W | Weight column address |
| wrData | input | WT_W | Unsigned weight value |
| xWrEn | input | 1 | Initial state write strobe |
| xWrIdx | input | IDX_W | State element address for writes |
| xWrData | input | ST_W | Signed state value |
| maxIter | input | ITER_W | Iteration limit |
| start | input | 1 | Start pulse for a recall |
| rdIdx | input | IDX_W | State element address for reads |
| rdData | output | ST_W | Selected state element |
| busy | output | 1 | Recall in progress |
| done | output | 1 | Recall ended with every element on the rail |
| timeout | output | 1 | Recall ended at the limit without convergence |
| iterCount | output | ITER_W | Iterations completed |

## Verification
The first pattern uses a unit diagonal in P with alternating ±64 inputs. It doubles each element every iteration, which gives an exact count of four and exact rail values of both signs. A half-weight diagonal grows the vector by a factor of 1.5, and stopping it at a limit of three exposes the unclipped values 96, 144 and 216. Run to the end, the same pattern overshoots to 1093, which separates a correct clip from a missing one.

Other patterns cover the rest of the behaviour. A unit diagonal in M cancels the feedback, collapsing the vector to zero and forcing the zero-limit timeout. A stored-pattern matrix with mixed P/M entries and three flipped inputs tests true cross-row summing and shadow buffering. A repeat of the first pattern with starts and writes during the run shows that those inputs are ignored.

// File: rtl/bsb_pkg.sv
package bsb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROW  = 2'd1,
    PH_SWAP = 2'd2
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadOk;    // idle: external writes allowed (R9)
    logic rowWrite;  // compute current row into shadow buffer
    logic swap;      // copy shadow buffer into live state
  } dpCtrl_t;

endpackage

// File: rtl/bsb_weight_bank.sv
module bsb_weight_bank #(
  parameter int N     = 16,
  parameter int WT_W  = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [IDX_W-1:0]           wrRow,
  input  logic [IDX_W-1:0]           wrCol,
  input  logic [WT_W-1:0]            wrData,
  input  logic [IDX_W-1:0]           rdRow,
  output logic [N-1:0][WT_W-1:0]     rowOut
);

  logic [N-1:0][N-1:0][WT_W-1:0] mem;

  // R1: register file, reset to zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mem <= '0;
    end else if (wrEn) begin
      mem[wrRow][wrCol] <= wrData;
    end
  end

  assign rowOut = mem[rdRow];

endmodule

// File: rtl/bsb_datapath.sv
module bsb_datapath
  import bsb_pkg::*;
#(
  parameter int N      = 16,
  parameter int ST_W   = 16,
  parameter int WT_W   = 8,
  parameter int ACC_W  = 32,
  parameter int WSHIFT = 6,
  parameter int BOUND  = 1024,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtrl_t                ctrl,
  input  logic [IDX_W-1:0]       rowIdx,
  input  logic                   wrEn,
  input  logic                   wrNeg,
  input  logic [IDX_W-1:0]       wrRow,
  input  logic [IDX_W-1:0]       wrCol,
  input  logic [WT_W-1:0]        wrData,
  input  logic                   xWrEn,
  input  logic [IDX_W-1:0]       xWrIdx,
  input  logic [ST_W-1:0]        xWrData,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [ST_W-1:0]        rdData,
  output logic                   convAll
);

  localparam int DIFF_W = WT_W + 2;
  localparam logic signed [ACC_W-1:0] BND_ACC = ACC_W'(BOUND);
  localparam logic signed [ST_W-1:0]  BND_ST  = ST_W'(BOUND);

  logic [1:0][N-1:0][WT_W-1:0] bankRow;  // [0]=P row, [1]=M row

  // One bank per sign of the connection matrix
  for (genvar b = 0; b < 2; b++) begin : g_bank
    bsb_weight_bank #(.N(N), .WT_W(WT_W), .IDX_W(IDX_W)) u_bank (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (wrEn && ctrl.loadOk && (wrNeg == b[0])),
      .wrRow  (wrRow),
      .wrCol  (wrCol),
      .wrData (wrData),
      .rdRow  (rowIdx),
      .rowOut (bankRow[b])
    );
  end

  logic signed [ST_W-1:0] xAct   [N];
  logic signed [ST_W-1:0] xShad  [N];
  logic [N-1:0]           convFlags;

  logic signed [ACC_W-1:0] rowAcc;
  logic signed [ACC_W-1:0] rowSum;
  logic signed [ST_W-1:0]  rowClip;

  // R3: signed row dot product over the old vector
  always_comb begin
    logic signed [DIFF_W-1:0] wDiff;
    rowAcc = '0;
    for (int j = 0; j < N; j++) begin
      wDiff  = $signed({2'b00, bankRow[0][j]}) - $signed({2'b00, bankRow[1][j]});
      rowAcc = rowAcc + ACC_W'(wDiff) * ACC_W'(xAct[j]);
    end
    rowSum = (rowAcc >>> WSHIFT) + ACC_W'(xAct[rowIdx]);
  end

  // R4: symmetric saturation
  always_comb begin
    if (rowSum >= BND_ACC)       rowClip = BND_ST;
    else if (rowSum <= -BND_ACC) rowClip = -BND_ST;
    else                         rowClip = rowSum[ST_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        xAct[i]  <= '0;
        xShad[i] <= '0;
      end
      convFlags <= '0;
    end else begin
      if (ctrl.loadOk && xWrEn) begin
        xAct[xWrIdx] <= xWrData;
      end
      if (ctrl.rowWrite) begin
        xShad[rowIdx]     <= rowClip;
        convFlags[rowIdx] <= (rowClip == BND_ST) || (rowClip == -BND_ST);
      end
      if (ctrl.swap) begin
        for (int i = 0; i < N; i++) xAct[i] <= xShad[i];
      end
    end
  end

  assign rdData  = xAct[rdIdx];
  assign convAll = &convFlags;  // R5

endmodule

// File: rtl/bsb_control.sv
module bsb_control
  import bsb_pkg::*;
#(
  parameter int N      = 16,
  parameter int ITER_W = 8,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ITER_W-1:0]  maxIter,
  input  logic               convAll,
  output dpCtrl_t            ctrl,
  output logic [IDX_W-1:0]   rowIdx,
  output logic               busy,
  output logic               done,
  output logic               timeout,
  output logic [ITER_W-1:0]  iterCount
);

  localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(N - 1);

  phase_e             phase;
  logic [ITER_W-1:0]  iterNext;

  assign iterNext = iterCount + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      rowIdx    <= '0;
      iterCount <= '0;
      done      <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin  // R8: flags cleared on accepted start
            phase     <= PH_ROW;
            rowIdx    <= '0;
            iterCount <= '0;
            done      <= 1'b0;
            timeout   <= 1'b0;
          end
        end
        PH_ROW: begin
          if (rowIdx == LAST_ROW) begin
            phase  <= PH_SWAP;
            rowIdx <= '0;
          end else begin
            rowIdx <= rowIdx + 1'b1;
          end
        end
        PH_SWAP: begin
          iterCount <= iterNext;  // R7
          if (convAll) begin      // R5, wins over limit (R6)
            done  <= 1'b1;
            phase <= PH_IDLE;
          end else if (iterNext >= maxIter) begin  // R6
            timeout <= 1'b1;
            phase   <= PH_IDLE;
          end else begin
            phase <= PH_ROW;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy          = (phase != PH_IDLE);
  assign ctrl.loadOk   = (phase == PH_IDLE);
  assign ctrl.rowWrite = (phase == PH_ROW);
  assign ctrl.swap     = (phase == PH_SWAP);

endmodule

// File: rtl/bsb_recall.sv
module bsb_recall
  import bsb_pkg::*;
#(
  parameter int N      = 16,
  parameter int ST_W   = 16,
  parameter int WT_W   = 8,
  parameter int ACC_W  = 32,
  parameter int WSHIFT = 6,
  parameter int BOUND  = 1024,
  parameter int ITER_W = 8,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               wrNeg,
  input  logic [IDX_W-1:0]   wrRow,
  input  logic [IDX_W-1:0]   wrCol,
  input  logic [WT_W-1:0]    wrData,
  input  logic               xWrEn,
  input  logic [IDX_W-1:0]   xWrIdx,
  input  logic [ST_W-1:0]    xWrData,
  input  logic [ITER_W-1:0]  maxIter,
  input  logic               start,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [ST_W-1:0]    rdData,
  output logic               busy,
  output logic               done,
  output logic               timeout,
  output logic [ITER_W-1:0]  iterCount
);

  dpCtrl_t           ctrl;
  logic [IDX_W-1:0]  rowIdx;
  logic              convAll;

  bsb_control #(.N(N), .ITER_W(ITER_W), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .maxIter   (maxIter),
    .convAll   (convAll),
    .ctrl      (ctrl),
    .rowIdx    (rowIdx),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .iterCount (iterCount)
  );

  bsb_datapath #(
    .N(N), .ST_W(ST_W), .WT_W(WT_W), .ACC_W(ACC_W),
    .WSHIFT(WSHIFT), .BOUND(BOUND), .IDX_W(IDX_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .rowIdx  (rowIdx),
    .wrEn    (wrEn),
    .wrNeg   (wrNeg),
    .wrRow   (wrRow),
    .wrCol   (wrCol),
    .wrData  (wrData),
    .xWrEn   (xWrEn),
    .xWrIdx  (xWrIdx),
    .xWrData (xWrData),
    .rdIdx   (rdIdx),
    .rdData  (rdData),
    .convAll (convAll)
  );

endmodule

// File: rtl/bsb_recall_checker.sv
module bsb_recall_checker #(
  parameter int ST_W   = 16,
  parameter int ITER_W = 8,
  parameter int BOUND  = 1024
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               timeout,
  input logic [ITER_W-1:0]  iterCount,
  input logic [ITER_W-1:0]  maxIter,
  input logic [ST_W-1:0]    rdData,
  input logic               convAll
);

  localparam logic signed [ST_W-1:0] BND = ST_W'(BOUND);

  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeout));

  assert_idle_on_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done || timeout) |-> !busy);

  assert_start_launch_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done && !timeout && iterCount == '0));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (iterCount != $past(iterCount)) |->
      ((iterCount == $past(iterCount) + 1'b1) || (iterCount == '0)));

  assert_done_on_rail_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> convAll);

  assert_timeout_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeout) |-> (!convAll && iterCount >= maxIter));

  assert_state_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(rdData) <= BND) && ($signed(rdData) >= -BND));

endmodule

bind bsb_recall bsb_recall_checker #(
  .ST_W(ST_W), .ITER_W(ITER_W), .BOUND(BOUND)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout),
  .iterCount (iterCount),
  .maxIter   (maxIter),
  .rdData    (rdData),
  .convAll   (convAll)
);

// File: tb/bsb_recall_bench.sv
module bsb_recall_bench;

  localparam int N   = 16;
  localparam int WS  = 6;
  localparam int BND = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrNeg = 1'b0;
  logic [3:0]  wrRow = '0, wrCol = '0;
  logic [7:0]  wrData = '0;
  logic        xWrEn = 1'b0;
  logic [3:0]  xWrIdx = '0;
  logic [15:0] xWrData = '0;
  logic [7:0]  maxIter = '0;
  logic        start = 1'b0;
  logic [3:0]  rdIdx = '0;
  logic [15:0] rdData;
  logic        busy, done, timeout;
  logic [7:0]  iterCount;

  bsb_recall u_bsb_recall (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrNeg(wrNeg), .wrRow(wrRow),
    .wrCol(wrCol), .wrData(wrData), .xWrEn(xWrEn), .xWrIdx(xWrIdx),
    .xWrData(xWrData), .maxIter(maxIter), .start(start), .rdIdx(rdIdx),
    .rdData(rdData), .busy(busy), .done(done), .timeout(timeout),
    .iterCount(iterCount)
  );

  always #5ns clk = ~clk;  // 100 MHz

  int nChecks = 0;
  int nFails  = 0;
  int nPopped = 0;

  // Scoreboard queues (parallel)
  logic [N*16-1:0] expVecQ [$];
  int              expIterQ [$];
  bit              expTmoQ [$];
  string           tagQ [$];

  int wP [N][N];
  int wM [N][N];
  int xInit [N];

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: R3/R4/R5/R6 from the requirements
  task automatic model(input int lim, output logic [N*16-1:0] vec,
                       output int iters, output bit tmo);
    int cur [N];
    int nxt [N];
    bit conv;
    longint acc;
    for (int i = 0; i < N; i++) cur[i] = xInit[i];
    iters = 0;
    conv  = 0;
    tmo   = 0;
    while (1) begin
      conv = 1;
      for (int i = 0; i < N; i++) begin
        acc = 0;
        for (int j = 0; j < N; j++) acc += longint'(wP[i][j] - wM[i][j]) * cur[j];
        acc = (acc >>> WS) + cur[i];
        if (acc >= BND) nxt[i] = BND;
        else if (acc <= -BND) nxt[i] = -BND;
        else nxt[i] = int'(acc);
        if (nxt[i] != BND && nxt[i] != -BND) conv = 0;
      end
      for (int i = 0; i < N; i++) cur[i] = nxt[i];
      iters++;
      if (conv) break;
      if (iters >= lim) begin tmo = 1; break; end
    end
    for (int i = 0; i < N; i++) vec[i*16 +: 16] = 16'(cur[i]);
  endtask

  task automatic clearW();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin wP[r][c] = 0; wM[r][c] = 0; end
  endtask

  task automatic loadAll();
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          @(negedge clk);
          wrEn = 1'b1; wrNeg = b[0]; wrRow = 4'(r); wrCol = 4'(c);
          wrData = 8'((b == 0) ? wP[r][c] : wM[r][c]);
        end
    @(negedge clk) wrEn = 1'b0;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      xWrEn = 1'b1; xWrIdx = 4'(i); xWrData = 16'(xInit[i]);
    end
    @(negedge clk) xWrEn = 1'b0;
  endtask

  // Driver: load, predict, push, launch, wait for monitor
  task automatic runRecall(input string tag, input int lim, input bit meddle);
    logic [N*16-1:0] ev;
    int ei;
    bit et;
    int target;
    loadAll();
    model(lim, ev, ei, et);
    expVecQ.push_back(ev); expIterQ.push_back(ei);
    expTmoQ.push_back(et); tagQ.push_back(tag);
    target = nPopped + 1;
    @(negedge clk);
    maxIter = 8'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R8 busy after start"}, int'(busy), 1);
    chk({tag, " R8 flags cleared"}, int'(done | timeout), 0);
    if (meddle) begin  // R9: start and writes while busy
      repeat (3) @(negedge clk);
      start = 1'b1; xWrEn = 1'b1; xWrIdx = 4'd0; xWrData = 16'sd500;
      wrEn = 1'b1; wrNeg = 1'b0; wrRow = 4'd0; wrCol = 4'd0; wrData = 8'd200;
      @(negedge clk);
      start = 1'b0; xWrEn = 1'b0; wrEn = 1'b0;
      repeat (N + 4) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    wait (nPopped == target);
    @(negedge clk);
  endtask

  // Monitor: timing, flags, vector
  int cyc = 0;
  bit prevFin = 0;
  initial begin
    forever begin
      @(posedge clk);
      if (start && !busy) cyc = 0; else cyc++;
      #1;
      if ((done || timeout) && !prevFin && rstN) begin
        if (expIterQ.size() == 0) begin
          nChecks++; nFails++;
          $display("FAIL R5 actual=unexpected result expected=none");
        end else begin
          logic [N*16-1:0] ev;
          int ei;
          bit et;
          string tg;
          ev = expVecQ.pop_front(); ei = expIterQ.pop_front();
          et = expTmoQ.pop_front(); tg = tagQ.pop_front();
          chk({tg, " R6 timeout flag"}, int'(timeout), int'(et));
          chk({tg, " R5 done flag"}, int'(done), int'(!et));
          chk({tg, " R7 iteration count"}, int'(iterCount), ei);
          chk({tg, " R7 cycles to result"}, cyc, ei * (N + 1));
          chk({tg, " R8 not busy"}, int'(busy), 0);
          for (int k = 0; k < N; k++) begin
            rdIdx = 4'(k);
            #1;
            chk({tg, " R2/R3/R4 element"}, int'($signed(rdData)),
                int'($signed(ev[k*16 +: 16])));
          end
        end
        nPopped++;
      end
      prevFin = done || timeout;
    end
  end

  // Watchdog
  initial begin
    #1ms;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 timeout", int'(timeout), 0);
    chk("R10 iterCount", int'(iterCount), 0);
    for (int k = 0; k < N; k++) begin
      rdIdx = 4'(k);
      #1 chk("R10 state zero", int'($signed(rdData)), 0);
    end

    // T1: R1 unit diagonal in P, doubling to both rails
    clearW();
    for (int i = 0; i < N; i++) begin wP[i][i] = 64; xInit[i] = (i % 2) ? -64 : 64; end
    runRecall("T1 unit diag", 20, 0);

    // T2: R6 convergence on the last allowed iteration wins
    runRecall("T2 limit equals count", 4, 0);

    // T3: R4 pass-through values, R6 timeout
    clearW();
    for (int i = 0; i < N; i++) wP[i][i] = 32;
    runRecall("T3 half diag limited", 3, 0);

    // T4: R4 overshoot clipped to rail
    runRecall("T4 half diag full", 20, 0);

    // T5: R1 negative bank, R6 zero limit
    clearW();
    for (int i = 0; i < N; i++) wM[i][i] = 64;
    runRecall("T5 cancel zero limit", 0, 0);

    // T6: R3 stored pattern with noisy input
    clearW();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        if (((i % 3 == 0) ? -1 : 1) * ((j % 3 == 0) ? -1 : 1) > 0) wP[i][j] = 4;
        else wM[i][j] = 4;
      end
    for (int i = 0; i < N; i++) xInit[i] = (i % 3 == 0) ? -64 : 64;
    xInit[1] = -64; xInit[5] = -64; xInit[9] = 64;
    runRecall("T6 pattern recall", 40, 0);

    // T7: R9 start and writes ignored while busy
    clearW();
    for (int i = 0; i < N; i++) begin wP[i][i] = 64; xInit[i] = (i % 2) ? -64 : 64; end
    runRecall("T7 R9 ignore while busy", 20, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule